// File: doc/BRIEF.md
# Translation Buffer with Access-Rights Check

This block is a fully associative address-translation cache. A requester presents a virtual address with a lookup strobe, a write flag and a privilege flag. One clock later the block returns a physical address and exactly one of three outcomes: a clean hit, a miss, or a protection fault. The low 12 address bits are the in-page offset and pass through unchanged. The page-number bits are matched against every stored entry in parallel.

Each entry holds its own page-size code, so ordinary 4 KB pages and 2 MB or 4 MB large pages can sit side by side. A large entry ignores the low page-number bits that fall inside the large page. Those bits are taken from the incoming address when the physical address is formed. The access-rights check runs in the same cycle as the match.

Entries are installed through a fill port. The fill port writes to a round-robin slot pointer. A flush input invalidates the whole array in one cycle. Misses are only reported. Walking the page table and retrying are left to the requester.

Top module: `tlb_xlate`

## Requirements
- R1: A synchronous reset clears every valid bit, sets the fill pointer to slot 0 and drives `rsp_valid`, `rsp_hit`, `rsp_miss`, `rsp_fault` and `rsp_pa` to zero.
- R2: A response appears on the clock edge after a cycle with `lk_req` high. `rsp_valid` is then 1 and exactly one of hit, miss or fault is 1. In a cycle without `lk_req`, all four flags are 0 at the following edge.
- R3: Size code 0 (4 KB) matches all VA bits 31..12. On a hit, `rsp_pa` = {stored PPN, VA[11:0]}.
- R4: Size code 1 (2 MB) matches VA bits 31..21 only. On a hit, PA[31:21] comes from the stored PPN and PA[20:0] from the VA. The low 9 PPN bits are ignored.
- R5: Size code 2 (4 MB) matches VA bits 31..22 only. On a hit, PA[31:22] comes from the stored PPN and PA[21:0] from the VA.
- R6: A lookup that matches no valid entry gives `rsp_miss`=1 and `rsp_pa`=0.
- R7: With `lk_kern`=0, an access to an entry whose user bit is 0 gives `rsp_fault`=1 and `rsp_pa`=0. With `lk_kern`=1, the user bit is not checked.
- R8: A write (`lk_wr`=1) to an entry whose writable bit is 0 faults in both privilege levels. A read of the same entry hits.
- R9: When several valid entries match, the entry with the lowest slot index supplies the translation and the permissions.
- R10: Each fill writes the slot under the pointer. The pointer then steps up by one and wraps from ENTRIES-1 to 0, so fill number ENTRIES+1 overwrites slot 0.
- R11: `flush` invalidates all entries and returns the pointer to 0 at the next edge. A fill in the same cycle is discarded.
- R12: A fill with size code 3 takes a slot and advances the pointer, but it leaves that slot invalid, so it never matches.
- R13: A lookup in the same cycle as a fill or a flush sees the contents from before that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| lk_req | input | 1 | Lookup strobe |
| lk_va | input | VA_W | Virtual address |
| lk_wr | input | 1 | 1 = write access, 0 = read |
| lk_kern | input | 1 | 1 = privileged, 0 = user |
| fl_en | input | 1 | Fill strobe |
| fl_vpn | input | VA_W-12 | Virtual page number to install |
| fl_ppn | input | PA_W-12 | Physical page number to install |
| fl_size | input | 2 | Page-size code: 0 = 4 KB, 1 = 2 MB, 2 = 4 MB, 3 = reserved |
| fl_user | input | 1 | Entry usable from user level |
| fl_wr | input | 1 | Entry writable |
| flush | input | 1 | Invalidate all entries |
| rsp_valid | output | 1 | Response present |
| rsp_hit | output | 1 | Translation succeeded |
| rsp_miss | output | 1 | No valid entry matched |
| rsp_fault | output | 1 | Matched, but the access was refused |
| rsp_pa | output | PA_W | Physical address, 0 unless hit |

## Verification
A corrupted valid bit or tag shows up one cycle after the next lookup to that page. It appears as a miss where a hit was due, or as a hit that the bench did not expect. A wrong size code or a wrong priority choice shows as a changed physical address in the high or middle bits within that same cycle. A fill pointer that drifts stays hidden until the array wraps: the overwrite test only shows it when fill number ENTRIES+1 evicts a slot other than slot 0. The bench therefore fills the whole array and probes both the evicted page and a neighbour.

// File: rtl/tlb_pkg.sv
package tlb_pkg;
  localparam int PG_OFS_W = 12;
  localparam int SH_2M    = 9;
  localparam int SH_4M    = 10;

  typedef enum logic [1:0] {
    PG_4K  = 2'd0,
    PG_2M  = 2'd1,
    PG_4M  = 2'd2,
    PG_RSV = 2'd3
  } pg_size_e;
endpackage

// File: rtl/tlb_entry_store.sv
module tlb_entry_store
  import tlb_pkg::*;
#(
  parameter int ENTRIES = 128,
  parameter int VPN_W   = 20,
  parameter int PPN_W   = 20
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             flush,
  input  logic             fl_en,
  input  logic [VPN_W-1:0] fl_vpn,
  input  logic [PPN_W-1:0] fl_ppn,
  input  pg_size_e         fl_size,
  input  logic             fl_user,
  input  logic             fl_wr,
  output logic             ent_valid [ENTRIES],
  output logic [VPN_W-1:0] ent_vpn   [ENTRIES],
  output logic [PPN_W-1:0] ent_ppn   [ENTRIES],
  output pg_size_e         ent_size  [ENTRIES],
  output logic             ent_user  [ENTRIES],
  output logic             ent_wr    [ENTRIES]
);
  localparam int IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;
  localparam logic [IDX_W-1:0] LAST = IDX_W'(ENTRIES - 1);

  logic [IDX_W-1:0] wr_ptr;
  logic             do_fill;

  assign do_fill = fl_en && !flush;

  // replacement pointer
  always_ff @(posedge clk) begin
    if (rst || flush) begin
      wr_ptr <= '0;
    end else if (fl_en) begin
      wr_ptr <= (wr_ptr == LAST) ? '0 : wr_ptr + 1'b1;
    end
  end

  // payload arrays: no reset, single write port
  always_ff @(posedge clk) begin
    if (do_fill) begin
      ent_vpn[wr_ptr]  <= fl_vpn;
      ent_ppn[wr_ptr]  <= fl_ppn;
      ent_size[wr_ptr] <= fl_size;
      ent_user[wr_ptr] <= fl_user;
      ent_wr[wr_ptr]   <= fl_wr;
    end
  end

  // valid bits: reset and flush together
  generate
    for (genvar g = 0; g < ENTRIES; g++) begin : g_valid
      always_ff @(posedge clk) begin
        if (rst || flush) begin
          ent_valid[g] <= 1'b0;
        end else if (fl_en && (wr_ptr == IDX_W'(g))) begin
          ent_valid[g] <= (fl_size != PG_RSV);
        end
      end
    end
  endgenerate
endmodule

// File: rtl/tlb_match.sv
module tlb_match
  import tlb_pkg::*;
#(
  parameter int ENTRIES = 128,
  parameter int VPN_W   = 20,
  parameter int IDX_W   = 7
) (
  input  logic             [VPN_W-1:0] va_vpn,
  input  logic                         ent_valid [ENTRIES],
  input  logic             [VPN_W-1:0] ent_vpn   [ENTRIES],
  input  pg_size_e                     ent_size  [ENTRIES],
  output logic                         any_hit,
  output logic             [IDX_W-1:0] sel_idx
);
  localparam logic [VPN_W-1:0] MASK_4K = '1;
  localparam logic [VPN_W-1:0] MASK_2M = {{(VPN_W-SH_2M){1'b1}}, {SH_2M{1'b0}}};
  localparam logic [VPN_W-1:0] MASK_4M = {{(VPN_W-SH_4M){1'b1}}, {SH_4M{1'b0}}};

  logic [ENTRIES-1:0] hit_vec;

  generate
    for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
      logic [VPN_W-1:0] cmp_mask;
      always_comb begin
        unique case (ent_size[g])
          PG_2M:   cmp_mask = MASK_2M;
          PG_4M:   cmp_mask = MASK_4M;
          default: cmp_mask = MASK_4K;
        endcase
      end
      assign hit_vec[g] = ent_valid[g] &&
                          (((va_vpn ^ ent_vpn[g]) & cmp_mask) == '0);
    end
  endgenerate

  // lowest index has priority
  always_comb begin
    sel_idx = '0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (hit_vec[i]) sel_idx = IDX_W'(i);
    end
  end

  assign any_hit = |hit_vec;
endmodule

// File: rtl/tlb_resp.sv
module tlb_resp
  import tlb_pkg::*;
#(
  parameter int VA_W = 32,
  parameter int PA_W = 32
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            lk_req,
  input  logic [VA_W-1:0] lk_va,
  input  logic            lk_wr,
  input  logic            lk_kern,
  input  logic            any_hit,
  input  logic [PA_W-PG_OFS_W-1:0] sel_ppn,
  input  pg_size_e        sel_size,
  input  logic            sel_user,
  input  logic            sel_wr,
  output logic            rsp_valid,
  output logic            rsp_hit,
  output logic            rsp_miss,
  output logic            rsp_fault,
  output logic [PA_W-1:0] rsp_pa
);
  localparam int PPN_W = PA_W - PG_OFS_W;
  localparam logic [PPN_W-1:0] KEEP_4K = '1;
  localparam logic [PPN_W-1:0] KEEP_2M = {{(PPN_W-SH_2M){1'b1}}, {SH_2M{1'b0}}};
  localparam logic [PPN_W-1:0] KEEP_4M = {{(PPN_W-SH_4M){1'b1}}, {SH_4M{1'b0}}};

  logic [PPN_W-1:0] keep;
  logic [PPN_W-1:0] va_low;
  logic [PPN_W-1:0] pa_ppn;
  logic             deny;

  always_comb begin
    unique case (sel_size)
      PG_2M:   keep = KEEP_2M;
      PG_4M:   keep = KEEP_4M;
      default: keep = KEEP_4K;
    endcase
  end

  assign va_low = {{(PPN_W-SH_4M){1'b0}}, lk_va[PG_OFS_W +: SH_4M]};
  assign pa_ppn = (sel_ppn & keep) | (va_low & ~keep);
  assign deny   = (!lk_kern && !sel_user) || (lk_wr && !sel_wr);

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid <= 1'b0;
      rsp_hit   <= 1'b0;
      rsp_miss  <= 1'b0;
      rsp_fault <= 1'b0;
      rsp_pa    <= '0;
    end else begin
      rsp_valid <= lk_req;
      rsp_hit   <= lk_req && any_hit && !deny;
      rsp_miss  <= lk_req && !any_hit;
      rsp_fault <= lk_req && any_hit && deny;
      rsp_pa    <= (lk_req && any_hit && !deny) ?
                   {pa_ppn, lk_va[PG_OFS_W-1:0]} : '0;
    end
  end
endmodule

// File: rtl/tlb_xlate.sv
module tlb_xlate
  import tlb_pkg::*;
#(
  parameter int VA_W    = 32,
  parameter int PA_W    = 32,
  parameter int ENTRIES = 128
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     lk_req,
  input  logic [VA_W-1:0]          lk_va,
  input  logic                     lk_wr,
  input  logic                     lk_kern,
  input  logic                     fl_en,
  input  logic [VA_W-PG_OFS_W-1:0] fl_vpn,
  input  logic [PA_W-PG_OFS_W-1:0] fl_ppn,
  input  logic [1:0]               fl_size,
  input  logic                     fl_user,
  input  logic                     fl_wr,
  input  logic                     flush,
  output logic                     rsp_valid,
  output logic                     rsp_hit,
  output logic                     rsp_miss,
  output logic                     rsp_fault,
  output logic [PA_W-1:0]          rsp_pa
);
  localparam int VPN_W = VA_W - PG_OFS_W;
  localparam int PPN_W = PA_W - PG_OFS_W;
  localparam int IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;

  logic             ent_valid [ENTRIES];
  logic [VPN_W-1:0] ent_vpn   [ENTRIES];
  logic [PPN_W-1:0] ent_ppn   [ENTRIES];
  pg_size_e         ent_size  [ENTRIES];
  logic             ent_user  [ENTRIES];
  logic             ent_wr    [ENTRIES];

  logic             any_hit;
  logic [IDX_W-1:0] sel_idx;

  tlb_entry_store #(
    .ENTRIES(ENTRIES), .VPN_W(VPN_W), .PPN_W(PPN_W)
  ) u_store (
    .clk      (clk),
    .rst      (rst),
    .flush    (flush),
    .fl_en    (fl_en),
    .fl_vpn   (fl_vpn),
    .fl_ppn   (fl_ppn),
    .fl_size  (pg_size_e'(fl_size)),
    .fl_user  (fl_user),
    .fl_wr    (fl_wr),
    .ent_valid(ent_valid),
    .ent_vpn  (ent_vpn),
    .ent_ppn  (ent_ppn),
    .ent_size (ent_size),
    .ent_user (ent_user),
    .ent_wr   (ent_wr)
  );

  tlb_match #(
    .ENTRIES(ENTRIES), .VPN_W(VPN_W), .IDX_W(IDX_W)
  ) u_match (
    .va_vpn   (lk_va[VA_W-1:PG_OFS_W]),
    .ent_valid(ent_valid),
    .ent_vpn  (ent_vpn),
    .ent_size (ent_size),
    .any_hit  (any_hit),
    .sel_idx  (sel_idx)
  );

  tlb_resp #(
    .VA_W(VA_W), .PA_W(PA_W)
  ) u_resp (
    .clk      (clk),
    .rst      (rst),
    .lk_req   (lk_req),
    .lk_va    (lk_va),
    .lk_wr    (lk_wr),
    .lk_kern  (lk_kern),
    .any_hit  (any_hit),
    .sel_ppn  (ent_ppn[sel_idx]),
    .sel_size (ent_size[sel_idx]),
    .sel_user (ent_user[sel_idx]),
    .sel_wr   (ent_wr[sel_idx]),
    .rsp_valid(rsp_valid),
    .rsp_hit  (rsp_hit),
    .rsp_miss (rsp_miss),
    .rsp_fault(rsp_fault),
    .rsp_pa   (rsp_pa)
  );
endmodule

// File: rtl/tlb_xlate_chk.sv
module tlb_xlate_chk #(
  parameter int VA_W = 32,
  parameter int PA_W = 32
) (
  input logic            clk,
  input logic            rst,
  input logic            lk_req,
  input logic [VA_W-1:0] lk_va,
  input logic            flush,
  input logic            rsp_valid,
  input logic            rsp_hit,
  input logic            rsp_miss,
  input logic            rsp_fault,
  input logic [PA_W-1:0] rsp_pa
);
  // R2: one outcome per response
  a_r2_one_outcome: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |-> $countones({rsp_hit, rsp_miss, rsp_fault}) == 1);

  // R2: strobe produces a response next cycle
  a_r2_resp_follows: assert property (@(posedge clk) disable iff (rst)
    lk_req |=> rsp_valid);

  // R2: no strobe, no flags
  a_r2_quiet: assert property (@(posedge clk) disable iff (rst)
    !lk_req |=> !(rsp_valid || rsp_hit || rsp_miss || rsp_fault));

  // R3: offset passes through on a hit
  a_r3_offset_kept: assert property (@(posedge clk) disable iff (rst)
    lk_req |=> (!rsp_hit || rsp_pa[11:0] == $past(lk_va[11:0])));

  // R6, R7: no address leaks on miss or fault
  a_r6_r7_pa_zero: assert property (@(posedge clk) disable iff (rst)
    (rsp_miss || rsp_fault) |-> rsp_pa == '0);

  // R11: first lookup after a flush misses
  a_r11_flush_empties: assert property (@(posedge clk) disable iff (rst)
    ($past(flush) && lk_req) |=> rsp_miss);
endmodule

bind tlb_xlate tlb_xlate_chk #(.VA_W(VA_W), .PA_W(PA_W)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .lk_req   (lk_req),
  .lk_va    (lk_va),
  .flush    (flush),
  .rsp_valid(rsp_valid),
  .rsp_hit  (rsp_hit),
  .rsp_miss (rsp_miss),
  .rsp_fault(rsp_fault),
  .rsp_pa   (rsp_pa)
);

// File: tb/tlb_xlate_bench.sv
module tlb_xlate_bench;
  localparam int VA_W    = 32;
  localparam int PA_W    = 32;
  localparam int ENTRIES = 128;

  typedef struct {
    logic        hit;
    logic        miss;
    logic        fault;
    logic [31:0] pa;
    string       tag;
  } exp_t;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        lk_req = 1'b0;
  logic [31:0] lk_va = '0;
  logic        lk_wr = 1'b0;
  logic        lk_kern = 1'b0;
  logic        fl_en = 1'b0;
  logic [19:0] fl_vpn = '0;
  logic [19:0] fl_ppn = '0;
  logic [1:0]  fl_size = '0;
  logic        fl_user = 1'b0;
  logic        fl_wr = 1'b0;
  logic        flush = 1'b0;
  logic        rsp_valid, rsp_hit, rsp_miss, rsp_fault;
  logic [31:0] rsp_pa;

  int   n_checks = 0;
  int   n_errors = 0;
  bit   done = 1'b0;
  exp_t sb[$];

  always #10 clk = ~clk;

  tlb_xlate #(.VA_W(VA_W), .PA_W(PA_W), .ENTRIES(ENTRIES)) u_tlb_xlate (
    .clk(clk), .rst(rst), .lk_req(lk_req), .lk_va(lk_va), .lk_wr(lk_wr),
    .lk_kern(lk_kern), .fl_en(fl_en), .fl_vpn(fl_vpn), .fl_ppn(fl_ppn),
    .fl_size(fl_size), .fl_user(fl_user), .fl_wr(fl_wr), .flush(flush),
    .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_miss(rsp_miss),
    .rsp_fault(rsp_fault), .rsp_pa(rsp_pa)
  );

  task automatic check(input bit ok, input string tag, input logic [35:0] act,
                       input logic [35:0] exp);
    n_checks++;
    if (!ok) begin
      n_errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // monitor: pops the scoreboard on each response
  always @(negedge clk) begin
    if (!rst && rsp_valid) begin
      if (sb.size() == 0) begin
        check(1'b0, "R2 unexpected response", {1'b1, rsp_hit, rsp_miss, rsp_fault, rsp_pa}, '0);
      end else begin
        exp_t e;
        e = sb.pop_front();
        check({rsp_hit, rsp_miss, rsp_fault, rsp_pa} == {e.hit, e.miss, e.fault, e.pa},
              e.tag, {1'b0, rsp_hit, rsp_miss, rsp_fault, rsp_pa},
              {1'b0, e.hit, e.miss, e.fault, e.pa});
      end
    end
  end

  task automatic fill(input logic [19:0] vpn, input logic [19:0] ppn,
                      input logic [1:0] sz, input logic usr, input logic wr);
    fl_en = 1'b1; fl_vpn = vpn; fl_ppn = ppn; fl_size = sz; fl_user = usr; fl_wr = wr;
    @(negedge clk);
    fl_en = 1'b0;
  endtask

  // outcome code: 0 hit, 1 miss, 2 fault
  task automatic look(input logic [31:0] va, input logic wr, input logic kern,
                      input int outcome, input logic [31:0] pa, input string tag);
    exp_t e;
    e.hit = (outcome == 0); e.miss = (outcome == 1); e.fault = (outcome == 2);
    e.pa = (outcome == 0) ? pa : 32'h0;
    e.tag = tag;
    sb.push_back(e);
    lk_req = 1'b1; lk_va = va; lk_wr = wr; lk_kern = kern;
    @(negedge clk);
    lk_req = 1'b0;
  endtask

  task automatic do_flush();
    flush = 1'b1;
    @(negedge clk);
    flush = 1'b0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    check(1'b0, "watchdog expired", 36'd0, 36'd1);
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1: outputs zero after reset
    check({rsp_valid, rsp_hit, rsp_miss, rsp_fault, rsp_pa} == '0, "R1 reset outputs",
          {rsp_valid, rsp_hit, rsp_miss, rsp_fault, rsp_pa}, '0);
    look(32'h1234_5678, 0, 1, 1, 0, "R1 empty array misses");

    // R3: 4 KB page
    fill(20'h12345, 20'hABCDE, 2'd0, 1, 1);
    look(32'h1234_5678, 0, 0, 0, 32'hABCD_E678, "R3 4K hit");
    look(32'h1234_6678, 0, 0, 1, 0, "R6 neighbour 4K page misses");

    // R2: no strobe, no flags
    lk_va = 32'h1234_5000;
    @(negedge clk);
    check({rsp_valid, rsp_hit, rsp_miss, rsp_fault} == 4'b0, "R2 quiet without strobe",
          {32'h0, rsp_valid, rsp_hit, rsp_miss, rsp_fault}, '0);

    // R4: 2 MB page
    fill(20'h40200, 20'h80400, 2'd1, 1, 1);
    look(32'h4031_2345, 0, 0, 0, 32'h8051_2345, "R4 2M hit");
    look(32'h4040_0000, 0, 0, 1, 0, "R4 outside 2M range");

    // R5: 4 MB page, unaligned PPN low bits ignored
    fill(20'hC0000, 20'h01155, 2'd2, 1, 1);
    look(32'hC03F_FFFC, 0, 0, 0, 32'h013F_FFFC, "R5 4M hit");

    // R7: kernel-only page
    fill(20'h00100, 20'h00200, 2'd0, 0, 1);
    look(32'h0010_0004, 0, 0, 2, 0, "R7 user to kernel page faults");
    look(32'h0010_0004, 0, 1, 0, 32'h0020_0004, "R7 kernel read hits");
    look(32'h0010_0008, 1, 1, 0, 32'h0020_0008, "R7 kernel write hits");

    // R8: read-only page
    fill(20'h00300, 20'h00400, 2'd0, 1, 0);
    look(32'h0030_0010, 1, 0, 2, 0, "R8 user write faults");
    look(32'h0030_0010, 1, 1, 2, 0, "R8 kernel write faults");
    look(32'h0030_0010, 0, 0, 0, 32'h0040_0010, "R8 user read hits");

    // R12: reserved size never matches
    fill(20'h00500, 20'h00600, 2'd3, 1, 1);
    look(32'h0050_0000, 0, 1, 1, 0, "R12 reserved size misses");

    // R13: lookup in the fill cycle sees old contents
    fl_en = 1'b1; fl_vpn = 20'h00600; fl_ppn = 20'h00700; fl_size = 2'd0; fl_user = 1; fl_wr = 1;
    look(32'h0060_0000, 0, 1, 1, 0, "R13 same-cycle fill not visible");
    fl_en = 1'b0;
    look(32'h0060_0000, 0, 1, 0, 32'h0070_0000, "R13 fill visible next cycle");

    // R11: flush, with a fill in the same cycle discarded
    fl_en = 1'b1; fl_vpn = 20'h00800; fl_ppn = 20'h00900; fl_size = 2'd0;
    do_flush();
    fl_en = 1'b0;
    look(32'h1234_5678, 0, 1, 1, 0, "R11 flushed entry misses");
    look(32'h0080_0000, 0, 1, 1, 0, "R11 fill during flush dropped");

    // R9: lowest slot wins, independent of size
    fill(20'h7FC00, 20'h11000, 2'd2, 1, 1);
    fill(20'h7FC01, 20'h22222, 2'd0, 1, 1);
    look(32'h7FC0_1ABC, 0, 1, 0, 32'h1100_1ABC, "R9 slot0 4M beats slot1 4K");
    do_flush();
    fill(20'h7FC01, 20'h22222, 2'd0, 1, 1);
    fill(20'h7FC00, 20'h11000, 2'd2, 1, 1);
    look(32'h7FC0_1ABC, 0, 1, 0, 32'h2222_2ABC, "R9 slot0 4K beats slot1 4M");

    // R10: round-robin wrap
    do_flush();
    fill(20'h0AAAA, 20'h0BBBB, 2'd0, 1, 1);
    for (int i = 1; i < ENTRIES; i++) fill(20'h30000 + 20'(i), 20'(i), 2'd0, 1, 1);
    look(32'h0AAA_A123, 0, 1, 0, 32'h0BBB_B123, "R10 slot0 held while array fills");
    fill(20'h0CCCC, 20'h0DDDD, 2'd0, 1, 1);
    look(32'h0AAA_A123, 0, 1, 1, 0, "R10 slot0 evicted on wrap");
    look(32'h0CCC_C001, 0, 1, 0, 32'h0DDD_D001, "R10 new entry in slot0");
    look(32'h3000_1040, 0, 1, 0, 32'h0000_1040, "R10 slot1 untouched");

    repeat (2) @(negedge clk);
    check(sb.size() == 0, "R2 all responses arrived", 36'(sb.size()), 36'd0);
    finish_run();
  end
endmodule